// File: doc/BRIEF.md
# Byte-stream memory word loader

The loader sits between a byte source and the write port of a RAM. It is typically used at power-up to fill a memory from an initialisation image that arrives as a serial sequence of bytes. Each incoming byte is taken over a valid/ready handshake, and a marker flags the final byte of the image. The loader gathers as many bytes as one memory word needs, which is the word width rounded up to whole bytes. It then issues a single write strobe together with an address and a data word.

Addresses start at zero and advance by one for each finished word. If a word is not a whole number of bytes wide, the spare high bits of its byte group are thrown away. If the image ends partway through a word, the bytes that did not arrive are treated as zero and the word is still written.

When the RAM's depth has been used up, the loader keeps taking bytes but throws them away, and it raises a sticky overflow indication. A completion flag reports that the image has been fully handled. A start pulse rearms the loader for a fresh image at address zero.

Top module: `byte_word_loader`

## Requirements
- R1: A word is built from ceil(WORD_W/8) accepted bytes. The first byte of a group occupies bits 7:0, the next byte bits 15:8, and so on (for WORD_W=32, bytes FF 11 EE 22 give 0x22EE11FF). With WORD_W=8, each byte is written as its own word, in arrival order.
- R2: Finished words are written to addresses 0, 1, 2, … in order, one address per word.
- R3: If WORD_W is smaller than 8×ceil(WORD_W/8), only the low WORD_W bits of the byte group are written. For WORD_W=9, bytes FF 11 give 0x1FF. For WORD_W=7, bit 7 of every byte is discarded.
- R4: If the byte with in_last set leaves a word only partly filled, that word is still written, with its missing high bytes set to zero (for WORD_W=32, bytes BB 55 followed by the end of the image give 0x000055BB).
- R5: wr_en is high for exactly one cycle per word. That cycle directly follows the clock edge at which the completing byte was accepted, and in_ready is low during it.
- R6: done rises in the cycle after the write of the word containing the last byte. It stays high until start or rst, and in_ready is low while done is high.
- R7: Once DEPTH words have been written, further bytes are still accepted but cause no write, and overflow goes high and stays high until start or rst. A last byte received in this state still sets done.
- R8: A start pulse returns the address to 0, discards any partly built word, and clears done and overflow.
- R9: An active-high synchronous rst brings the block to its idle state: in_ready=1, wr_en=0, wr_addr=0, done=0 and overflow=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Restart pulse: rearms loading at address 0 |
| in_valid | input | 1 | A byte is offered on in_byte |
| in_byte | input | 8 | Incoming byte |
| in_last | input | 1 | The offered byte is the final byte of the image |
| in_ready | output | 1 | The loader takes the offered byte at the next clock edge |
| wr_en | output | 1 | Single-cycle RAM write strobe |
| wr_addr | output | ADDR_W | RAM word address |
| wr_data | output | WORD_W | RAM write data |
| done | output | 1 | The image has been fully handled (sticky) |
| overflow | output | 1 | Bytes arrived after the RAM was full (sticky) |

## Verification
A wrong byte counter shows up in the first written word as a byte in the wrong lane. It also shows up as a write that comes one byte early or late, so the error is visible within a single word. A bad address register is exposed by the second write, and a lost full indication by the first byte after DEPTH words, which would otherwise produce a write to an address past the end. A partial word that survives a start pulse or a reset corrupts the very next word written. The directed tests look for exactly these cases at the write port.

// File: rtl/bwl_pkg.sv
package bwl_pkg;

    // Number of bytes needed to hold one word of the given width.
    function automatic int unsigned bytes_for(input int unsigned width);
        return (width + 7) / 8;
    endfunction

    // Index width that never collapses to zero.
    function automatic int unsigned idx_w(input int unsigned count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/bwl_lane_merge.sv
// Places one byte into the lane selected by the byte counter. The other
// lanes keep the partial word gathered so far.
module bwl_lane_merge #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned CNT_W  = 2
) (
    input  logic [LANES*8-1:0] acc_i,
    input  logic [CNT_W-1:0]   lane_i,
    input  logic [7:0]         byte_i,
    output logic [LANES*8-1:0] merged_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged_o[g*8 +: 8] = (lane_i == CNT_W'(g)) ? byte_i : acc_i[g*8 +: 8];
    end
endmodule

// File: rtl/bwl_word_trim.sv
// Zeroes the lanes beyond the number of bytes actually received and keeps
// only the low WORD_W bits of the group.
module bwl_word_trim #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned LANES  = 4,
    parameter int unsigned CNT_W  = 3
) (
    input  logic [LANES*8-1:0] group_i,
    input  logic [CNT_W-1:0]   filled_i,
    output logic [WORD_W-1:0]  word_o
);
    localparam int unsigned GRP_W = LANES * 8;

    logic [GRP_W-1:0] masked;

    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign masked[g*8 +: 8] = (CNT_W'(g) < filled_i) ? group_i[g*8 +: 8] : 8'h00;
    end

    assign word_o = masked[WORD_W-1:0];

    if (GRP_W > WORD_W) begin : g_spare
        logic unused_spare_bits;
        assign unused_spare_bits = ^masked[GRP_W-1:WORD_W];
    end
endmodule

// File: rtl/byte_word_loader.sv
module byte_word_loader
    import bwl_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned ADDR_W = idx_w(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              in_last,
    output logic              in_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              done,
    output logic              overflow
);
    localparam int unsigned LANES  = bytes_for(WORD_W);
    localparam int unsigned GRP_W  = LANES * 8;
    localparam int unsigned BCNT_W = idx_w(LANES);
    localparam int unsigned FILL_W = BCNT_W + 1;
    localparam logic [BCNT_W-1:0] LAST_LANE = BCNT_W'(LANES - 1);
    localparam logic [ADDR_W-1:0] TOP_ADDR  = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic [GRP_W-1:0]  acc;
        logic [BCNT_W-1:0] bcnt;
        logic [ADDR_W-1:0] addr;
        logic              full;
        logic              wr_en;
        logic [WORD_W-1:0] wr_data;
        logic              wr_last;
        logic              done;
        logic              ovf;
    } state_t;

    state_t q, d;

    logic [GRP_W-1:0]  merged;
    logic [FILL_W-1:0] filled;
    logic [WORD_W-1:0] trimmed;
    logic              take;

    bwl_lane_merge #(
        .LANES (LANES),
        .CNT_W (BCNT_W)
    ) merge_i (
        .acc_i    (q.acc),
        .lane_i   (q.bcnt),
        .byte_i   (in_byte),
        .merged_o (merged)
    );

    assign filled = {1'b0, q.bcnt} + FILL_W'(1);

    bwl_word_trim #(
        .WORD_W (WORD_W),
        .LANES  (LANES),
        .CNT_W  (FILL_W)
    ) trim_i (
        .group_i  (merged),
        .filled_i (filled),
        .word_o   (trimmed)
    );

    assign in_ready = !q.wr_en && !q.done;
    assign take     = in_valid && in_ready;

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        if (start) begin
            d = '0;
        end else begin
            // Retire the word presented this cycle.
            if (q.wr_en) begin
                if (q.addr == TOP_ADDR) begin
                    d.full = 1'b1;
                end else begin
                    d.addr = q.addr + ADDR_W'(1);
                end
                if (q.wr_last) begin
                    d.done = 1'b1;
                end
            end
            // Accept an incoming byte.
            if (take) begin
                if (q.full) begin
                    d.ovf = 1'b1;
                    if (in_last) begin
                        d.done = 1'b1;
                    end
                end else if (q.bcnt == LAST_LANE || in_last) begin
                    d.wr_en   = 1'b1;
                    d.wr_data = trimmed;
                    d.wr_last = in_last;
                    d.acc     = '0;
                    d.bcnt    = '0;
                end else begin
                    d.acc  = merged;
                    d.bcnt = q.bcnt + BCNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_en    = q.wr_en;
    assign wr_addr  = q.addr;
    assign wr_data  = q.wr_data;
    assign done     = q.done;
    assign overflow = q.ovf;

endmodule

// File: rtl/bwl_checker.sv
module bwl_checker #(
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              in_ready,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              done,
    input logic              overflow
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEPTH - 1);

    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en); // R5
    AST_READY_LOW_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !in_ready); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !start && wr_addr != TOP_ADDR) |=> wr_addr == $past(wr_addr) + ADDR_W'(1)); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !start) |=> $stable(wr_addr)); // R2
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done); // R6
    AST_DONE_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        done |-> (!in_ready && !wr_en)); // R6
    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overflow && !start) |=> overflow); // R7
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start |=> (wr_addr == '0 && !done && !overflow && !wr_en)); // R8
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (wr_addr == '0 && !done && !overflow && !wr_en)); // R9
endmodule

bind byte_word_loader bwl_checker #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .in_ready (in_ready),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .done     (done),
    .overflow (overflow)
);

// File: tb/byte_word_loader_tb_top.sv
`timescale 1ns/1ps
module byte_word_loader_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    // 32-bit words, depth 4
    logic        st32 = 0, v32 = 0, l32 = 0, r32, e32, dn32, of32;
    logic [7:0]  b32 = 0;
    logic [1:0]  a32;
    logic [31:0] w32;
    // 9-bit words, depth 8
    logic        st9 = 0, v9 = 0, l9 = 0, r9, e9, dn9, of9;
    logic [7:0]  b9 = 0;
    logic [2:0]  a9;
    logic [8:0]  w9;
    // 7-bit words, depth 4
    logic        st7 = 0, v7 = 0, l7 = 0, r7, e7, dn7, of7;
    logic [7:0]  b7 = 0;
    logic [1:0]  a7;
    logic [6:0]  w7;

    byte_word_loader #(.WORD_W(32), .DEPTH(4)) dut_i (
        .clk(clk), .rst(rst), .start(st32), .in_valid(v32), .in_byte(b32), .in_last(l32),
        .in_ready(r32), .wr_en(e32), .wr_addr(a32), .wr_data(w32), .done(dn32), .overflow(of32));
    byte_word_loader #(.WORD_W(9), .DEPTH(8)) dut_w9 (
        .clk(clk), .rst(rst), .start(st9), .in_valid(v9), .in_byte(b9), .in_last(l9),
        .in_ready(r9), .wr_en(e9), .wr_addr(a9), .wr_data(w9), .done(dn9), .overflow(of9));
    byte_word_loader #(.WORD_W(7), .DEPTH(4)) dut_w7 (
        .clk(clk), .rst(rst), .start(st7), .in_valid(v7), .in_byte(b7), .in_last(l7),
        .in_ready(r7), .wr_en(e7), .wr_addr(a7), .wr_data(w7), .done(dn7), .overflow(of7));

    // Write logs and pulse-shape monitors
    int n32 = 0, n9 = 0, n7 = 0;
    int bad32 = 0, bad9 = 0, bad7 = 0;
    logic [31:0] log32_d [64];
    logic [3:0]  log32_a [64];
    logic [8:0]  log9_d  [64];
    logic [3:0]  log9_a  [64];
    logic [6:0]  log7_d  [64];
    logic [3:0]  log7_a  [64];
    logic p32 = 0, p9 = 0, p7 = 0;

    always @(negedge clk) begin
        if (e32) begin
            log32_d[n32 % 64] <= w32; log32_a[n32 % 64] <= 4'(a32); n32 <= n32 + 1;
            if (r32 || p32) bad32 <= bad32 + 1;
        end
        p32 <= e32;
    end
    always @(negedge clk) begin
        if (e9) begin
            log9_d[n9 % 64] <= w9; log9_a[n9 % 64] <= 4'(a9); n9 <= n9 + 1;
            if (r9 || p9) bad9 <= bad9 + 1;
        end
        p9 <= e9;
    end
    always @(negedge clk) begin
        if (e7) begin
            log7_d[n7 % 64] <= w7; log7_a[n7 % 64] <= 4'(a7); n7 <= n7 + 1;
            if (r7 || p7) bad7 <= bad7 + 1;
        end
        p7 <= e7;
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Byte drivers: called at a negedge, return at the negedge after acceptance.
    task automatic send32(input logic [7:0] b, input logic last);
        v32 = 1; b32 = b; l32 = last;
        while (!r32) @(negedge clk);
        @(negedge clk);
        v32 = 0; l32 = 0;
    endtask
    task automatic send9(input logic [7:0] b, input logic last);
        v9 = 1; b9 = b; l9 = last;
        while (!r9) @(negedge clk);
        @(negedge clk);
        v9 = 0; l9 = 0;
    endtask
    task automatic send7(input logic [7:0] b, input logic last);
        v7 = 1; b7 = b; l7 = last;
        while (!r7) @(negedge clk);
        @(negedge clk);
        v7 = 0; l7 = 0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    logic [7:0] img [10] = '{8'hFF, 8'h11, 8'hEE, 8'h22, 8'hDD, 8'h33, 8'hCC, 8'h44, 8'hBB, 8'h55};

    task automatic t_reset_state();
        check("R9 in_ready after reset", 32'(r32), 32'd1);
        check("R9 wr_en after reset", 32'(e32), 32'd0);
        check("R9 wr_addr after reset", 32'(a32), 32'd0);
        check("R9 done/overflow after reset", 32'({dn32, of32}), 32'd0);
    endtask

    task automatic t_wide_words();
        int base = n32;
        for (int i = 0; i < 10; i++) send32(img[i], i == 9);
        settle();
        check("R2 word count 32-bit", 32'(n32 - base), 32'd3);
        check("R1 word 0 data", log32_d[base % 64], 32'h22EE11FF);
        check("R2 word 0 addr", 32'(log32_a[base % 64]), 32'd0);
        check("R1 word 1 data", log32_d[(base + 1) % 64], 32'h44CC33DD);
        check("R2 word 1 addr", 32'(log32_a[(base + 1) % 64]), 32'd1);
        check("R4 short tail zero-filled", log32_d[(base + 2) % 64], 32'h000055BB);
        check("R2 word 2 addr", 32'(log32_a[(base + 2) % 64]), 32'd2);
        check("R6 done after tail", 32'(dn32), 32'd1);
        check("R6 in_ready low while done", 32'(r32), 32'd0);
    endtask

    task automatic t_nine_bit();
        logic [8:0] exp9 [5] = '{9'h1FF, 9'h0EE, 9'h1DD, 9'h0CC, 9'h1BB};
        int base = n9;
        for (int i = 0; i < 10; i++) send9(img[i], i == 9);
        settle();
        check("R3 word count 9-bit", 32'(n9 - base), 32'd5);
        for (int i = 0; i < 5; i++) begin
            check($sformatf("R3 9-bit word %0d", i), 32'(log9_d[(base + i) % 64]), 32'(exp9[i]));
            check($sformatf("R2 9-bit addr %0d", i), 32'(log9_a[(base + i) % 64]), 32'(i));
        end
        check("R6 done 9-bit", 32'(dn9), 32'd1);
    endtask

    task automatic t_seven_bit();
        int base = n7;
        send7(8'hFF, 0); send7(8'h80, 0); send7(8'h7F, 1);
        settle();
        check("R1 one byte per 7-bit word", 32'(n7 - base), 32'd3);
        check("R3 7-bit drops bit 7 (FF)", 32'(log7_d[base % 64]), 32'h7F);
        check("R3 7-bit drops bit 7 (80)", 32'(log7_d[(base + 1) % 64]), 32'h00);
        check("R3 7-bit keeps 7F", 32'(log7_d[(base + 2) % 64]), 32'h7F);
        check("R2 7-bit last addr", 32'(log7_a[(base + 2) % 64]), 32'd2);
    endtask

    task automatic t_start_discards_partial();
        int base;
        st32 = 1; @(negedge clk); st32 = 0;
        check("R8 start clears done", 32'(dn32), 32'd0);
        check("R8 start zeroes addr", 32'(a32), 32'd0);
        base = n32;
        send32(8'h12, 0); send32(8'h34, 0);
        st32 = 1; @(negedge clk); st32 = 0;
        send32(8'hA5, 1);
        settle();
        check("R8 one write after restart", 32'(n32 - base), 32'd1);
        check("R8 partial word discarded", log32_d[base % 64], 32'h000000A5);
        check("R8 restart addr 0", 32'(log32_a[base % 64]), 32'd0);
    endtask

    task automatic t_overflow();
        int base;
        st32 = 1; @(negedge clk); st32 = 0;
        base = n32;
        for (int i = 0; i < 16; i++) send32(8'(i + 1), 0);
        settle();
        check("R7 no overflow at exactly full", 32'(of32), 32'd0);
        send32(8'hEE, 0); send32(8'h77, 1);
        settle();
        check("R7 only DEPTH writes", 32'(n32 - base), 32'd4);
        check("R7 last in-range addr", 32'(log32_a[(base + 3) % 64]), 32'd3);
        check("R7 last in-range data", log32_d[(base + 3) % 64], 32'h100F0E0D);
        check("R7 overflow set", 32'(of32), 32'd1);
        check("R7 done after dropped last", 32'(dn32), 32'd1);
        st32 = 1; @(negedge clk); st32 = 0;
        check("R8 start clears overflow", 32'(of32), 32'd0);
    endtask

    task automatic t_mid_reset();
        int base;
        st9 = 1; @(negedge clk); st9 = 0;
        send9(8'h3C, 0);
        rst = 1; @(negedge clk); rst = 0;
        check("R9 reset mid-word ready", 32'(r9), 32'd1);
        check("R9 reset mid-word addr", 32'(a9), 32'd0);
        base = n9;
        send9(8'h01, 0); send9(8'h01, 1);
        settle();
        check("R9 partial cleared by reset", 32'(log9_d[base % 64]), 32'h101);
        check("R9 addr after reset", 32'(log9_a[base % 64]), 32'd0);
    endtask

    task automatic t_pulse_shape();
        check("R5 32-bit strobe single and ready low", 32'(bad32), 32'd0);
        check("R5 9-bit strobe single and ready low", 32'(bad9), 32'd0);
        check("R5 7-bit strobe single and ready low", 32'(bad7), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset_state();
        t_wide_words();
        t_nine_bit();
        t_seven_bit();
        t_start_discards_partial();
        t_overflow();
        t_mid_reset();
        t_pulse_shape();
        report();
    end

endmodule